// File: doc/BRIEF.md
# Bang-Bang Phase Decision Engine

This block is the digital decision core of a clock-and-data recovery loop. On each bit interval a front end hands it three samples of the incoming line, qualified by a valid strobe. The first is taken at the bit centre, the second near the edge that follows it, and the third at the next bit centre. From these three values the block works out whether the recovered clock is running early or late relative to the data. It then issues a single-cycle step request in one of two directions, or no request at all. The centre sample becomes the retimed data bit.

The same step requests also drive a digital integral path. This is a signed saturating accumulator that stands in for the centre-frequency control word of the oscillator. A short run-length filter sits in front of it, so that only a sustained run of same-direction corrections moves the frequency word. Isolated corrections act on phase only. A frequency-acquisition block can lower the enable input to suspend all phase decisions while it pulls the oscillator into range.

Top module: `bbpd_top`

## Requirements
- R1: While reset is held and directly after it, the data, data-valid, advance and retard outputs are 0 and the frequency word is 0.
- R2: On the clock edge where the strobe is high, the data output takes the centre sample, and the data-valid output is high for exactly the following cycle.
- R3: When the centre sample equals the next-centre sample, neither advance nor retard is raised, whatever the edge sample holds.
- R4: When the edge sample equals the centre sample but differs from the next-centre sample (clock early), the retard output is high in the cycle after the strobe.
- R5: When the edge sample equals the next-centre sample but differs from the centre sample (clock late), the advance output is high in the cycle after the strobe.
- R6: Each advance or retard pulse lasts one cycle. It is repeated only if another strobe with a transition arrives.
- R7: With the enable input low, no advance or retard pulse is produced and the run count is cleared. The data output still follows the centre sample.
- R8: Advance and retard are never high in the same cycle.
- R9: A qualified advance step adds INT_STEP to the frequency word, and a qualified retard step subtracts INT_STEP. The word changes one cycle after the corresponding pulse and is otherwise unchanged.
- R10: A step is qualified only when the correction completes a run of RUN_MIN same-direction corrections; once the run is complete, each further correction in that direction also qualifies. A strobe with no transition leaves the run intact. A correction in the opposite direction restarts the run at 1.
- R11: The frequency word saturates at the largest positive value (2^(INT_W-1)-1) and at the most negative value (-2^(INT_W-1)).
- R12: In a cycle without the strobe, the data output holds its value and data-valid, advance and retard are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample triple valid strobe |
| smp_a_i | input | 1 | Bit-centre sample |
| smp_t_i | input | 1 | Edge sample |
| smp_b_i | input | 1 | Next bit-centre sample |
| pd_en_i | input | 1 | Phase decision enable |
| rdata_o | output | 1 | Retimed data bit |
| rdata_vld_o | output | 1 | Retimed data valid |
| up_o | output | 1 | Advance (clock late) pulse |
| dn_o | output | 1 | Retard (clock early) pulse |
| fctl_o | output | INT_W | Signed centre-frequency control word |

## Verification
The bench targets triples whose two centre samples agree while the edge sample differs. A design that looked at the edge sample first would emit spurious corrections on those. It checks that a quiet strobe in the middle of a run does not reset the run-length count. It also checks that a reversal does restart it: a filter that got either wrong would move the frequency word too early or too late. The word is driven into both rails, where a missing clamp would wrap to the opposite sign. Enable is toggled in the middle of a run to catch pulses that leak through during acquisition, and to catch run state that survives it.

// File: rtl/bbpd_pkg.sv
`timescale 1ns/1ps
package bbpd_pkg;
   typedef enum logic [1:0] {
      DEC_HOLD = 2'b00,
      DEC_UP   = 2'b01,
      DEC_DN   = 2'b10
   } dec_e;
endpackage

// File: rtl/bbpd_decide.sv
`timescale 1ns/1ps
module bbpd_decide
   import bbpd_pkg::*;
(
   input  logic a_i,
   input  logic t_i,
   input  logic b_i,
   input  logic en_i,
   input  logic vld_i,
   output dec_e dec_o
);
   logic edge_seen;

   assign edge_seen = a_i ^ b_i;

   // a transition exists only when the two centres differ; the edge
   // sample then matches one side and tells which way the clock is off
   always_comb begin
      dec_o = DEC_HOLD;
      if (en_i && vld_i && edge_seen) begin
         if (t_i == a_i) dec_o = DEC_DN;
         else            dec_o = DEC_UP;
      end
   end
endmodule

// File: rtl/bbpd_run_filter.sv
`timescale 1ns/1ps
module bbpd_run_filter
   import bbpd_pkg::*;
#(
   parameter int RUN_MIN = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  dec_e dec_i,
   output logic step_up_o,
   output logic step_dn_o
);
   if (RUN_MIN < 1) begin : g_bad_run
      $error("RUN_MIN must be at least 1");
   end

   if (RUN_MIN == 1) begin : g_direct
      // every correction qualifies; no run state needed
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            step_up_o <= 1'b0;
            step_dn_o <= 1'b0;
         end else begin
            step_up_o <= (dec_i == DEC_UP);
            step_dn_o <= (dec_i == DEC_DN);
         end
      end
   end else begin : g_counted
      localparam int CNT_W = $clog2(RUN_MIN + 1);
      localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RUN_MIN);
      localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

      logic [CNT_W-1:0] cnt_q, cnt_d;
      dec_e             dir_q, dir_d;
      logic             up_d, dn_d;

      always_comb begin
         cnt_d = cnt_q;
         dir_d = dir_q;
         if (clr_i) begin
            cnt_d = '0;
            dir_d = DEC_HOLD;
         end else if (dec_i != DEC_HOLD) begin
            dir_d = dec_i;
            if (dir_q != dec_i)        cnt_d = CNT_ONE;
            else if (cnt_q != CNT_TOP) cnt_d = cnt_q + CNT_ONE;
         end
         up_d = (dec_i == DEC_UP) && (cnt_d == CNT_TOP);
         dn_d = (dec_i == DEC_DN) && (cnt_d == CNT_TOP);
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q     <= '0;
            dir_q     <= DEC_HOLD;
            step_up_o <= 1'b0;
            step_dn_o <= 1'b0;
         end else begin
            cnt_q     <= cnt_d;
            dir_q     <= dir_d;
            step_up_o <= up_d;
            step_dn_o <= dn_d;
         end
      end

      p_cnt_bound_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         cnt_q <= CNT_TOP);
   end

   p_up_needs_dec_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i != DEC_UP) |=> !step_up_o);
   p_dn_needs_dec_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i != DEC_DN) |=> !step_dn_o);
endmodule

// File: rtl/bbpd_integ.sv
`timescale 1ns/1ps
module bbpd_integ #(
   parameter int INT_W    = 8,
   parameter int INT_STEP = 4
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    inc_i,
   input  logic                    dec_i,
   output logic signed [INT_W-1:0] acc_o
);
   localparam int EXT_W = INT_W + 1;
   localparam logic signed [EXT_W-1:0] MAX_V  = {2'b00, {(INT_W-1){1'b1}}};
   localparam logic signed [EXT_W-1:0] MIN_V  = {2'b11, {(INT_W-1){1'b0}}};
   localparam logic signed [EXT_W-1:0] STEP_V = EXT_W'(INT_STEP);
   localparam logic signed [INT_W-1:0] MAX_N  = MAX_V[INT_W-1:0];
   localparam logic signed [INT_W-1:0] MIN_N  = MIN_V[INT_W-1:0];
   localparam logic signed [INT_W-1:0] HI_LIM = INT_W'((2 ** (INT_W-1)) - 1 - INT_STEP);
   localparam logic signed [INT_W-1:0] LO_LIM = INT_W'(INT_STEP - (2 ** (INT_W-1)));
   localparam logic signed [INT_W-1:0] STEP_N = INT_W'(INT_STEP);

   if (INT_W < 2 || INT_W > 31) begin : g_bad_w
      $error("INT_W out of range");
   end
   if (INT_STEP < 1 || INT_STEP >= (2 ** (INT_W-1))) begin : g_bad_step
      $error("INT_STEP must be positive and below the positive rail");
   end

   logic signed [EXT_W-1:0] ext, sum;
   logic signed [INT_W-1:0] nxt;

   always_comb begin
      ext = {acc_o[INT_W-1], acc_o};
      if (inc_i)      sum = ext + STEP_V;
      else if (dec_i) sum = ext - STEP_V;
      else            sum = ext;
      if (sum > MAX_V)      nxt = MAX_N;
      else if (sum < MIN_V) nxt = MIN_N;
      else                  nxt = sum[INT_W-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) acc_o <= '0;
      else         acc_o <= nxt;
   end

   p_idle_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !dec_i) |=> $stable(acc_o));
   p_inc_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && acc_o <= HI_LIM) |=> (acc_o == $past(acc_o) + STEP_N));
   p_dec_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i && !inc_i && acc_o >= LO_LIM) |=> (acc_o == $past(acc_o) - STEP_N));
   p_sat_hi_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && acc_o == MAX_N) |=> (acc_o == MAX_N));
   p_sat_lo_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i && !inc_i && acc_o == MIN_N) |=> (acc_o == MIN_N));
endmodule

// File: rtl/bbpd_top.sv
`timescale 1ns/1ps
module bbpd_top
   import bbpd_pkg::*;
#(
   parameter int INT_W    = 8,
   parameter int INT_STEP = 4,
   parameter int RUN_MIN  = 2
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    smp_vld_i,
   input  logic                    smp_a_i,
   input  logic                    smp_t_i,
   input  logic                    smp_b_i,
   input  logic                    pd_en_i,
   output logic                    rdata_o,
   output logic                    rdata_vld_o,
   output logic                    up_o,
   output logic                    dn_o,
   output logic signed [INT_W-1:0] fctl_o
);
   dec_e dec;
   logic step_up, step_dn;

   bbpd_decide u_decide (
      .a_i   (smp_a_i),
      .t_i   (smp_t_i),
      .b_i   (smp_b_i),
      .en_i  (pd_en_i),
      .vld_i (smp_vld_i),
      .dec_o (dec)
   );

   bbpd_run_filter #(.RUN_MIN(RUN_MIN)) u_run (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (!pd_en_i),
      .dec_i     (dec),
      .step_up_o (step_up),
      .step_dn_o (step_dn)
   );

   bbpd_integ #(.INT_W(INT_W), .INT_STEP(INT_STEP)) u_integ (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (step_up),
      .dec_i  (step_dn),
      .acc_o  (fctl_o)
   );

   // proportional path and retimed data, one register after the strobe
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_o     <= 1'b0;
         rdata_vld_o <= 1'b0;
         up_o        <= 1'b0;
         dn_o        <= 1'b0;
      end else begin
         rdata_vld_o <= smp_vld_i;
         if (smp_vld_i) rdata_o <= smp_a_i;
         up_o <= (dec == DEC_UP);
         dn_o <= (dec == DEC_DN);
      end
   end

   p_data_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_vld_i |=> (rdata_o == $past(smp_a_i)) && rdata_vld_o);
   p_hold_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_vld_i && (smp_a_i == smp_b_i)) |=> (!up_o && !dn_o));
   p_early_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_vld_i && pd_en_i && smp_a_i == smp_t_i && smp_a_i != smp_b_i) |=> dn_o);
   p_late_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_vld_i && pd_en_i && smp_b_i == smp_t_i && smp_a_i != smp_b_i) |=> up_o);
   p_one_cyc_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((up_o || dn_o) && !smp_vld_i) |=> (!up_o && !dn_o));
   p_disabled_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pd_en_i |=> (!up_o && !dn_o));
   p_excl_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(up_o && dn_o));
   p_quiet_r12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !smp_vld_i |=> ($stable(rdata_o) && !rdata_vld_o));
endmodule

// File: tb/bbpd_top_tb_top.sv
`timescale 1ns/1ps
module bbpd_top_tb_top;
   localparam int INT_W    = 8;
   localparam int INT_STEP = 4;
   localparam int RUN_MIN  = 2;
   localparam int F_MAX    = (2 ** (INT_W-1)) - 1;
   localparam int F_MIN    = -(2 ** (INT_W-1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vld = 1'b0, sa = 1'b0, st = 1'b0, sb = 1'b0, en = 1'b1;
   logic rdata, rvld, up, dn;
   logic signed [INT_W-1:0] fctl;

   int n_chk = 0;
   int n_bad = 0;

   // model state
   int m_freq = 0;
   int m_cnt = 0;
   int m_dir = 0;
   int m_pend = 0;
   logic m_dout = 1'b0;

   always #2.5 clk = ~clk;

   bbpd_top #(.INT_W(INT_W), .INT_STEP(INT_STEP), .RUN_MIN(RUN_MIN)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_a_i(sa), .smp_t_i(st),
      .smp_b_i(sb), .pd_en_i(en), .rdata_o(rdata), .rdata_vld_o(rvld),
      .up_o(up), .dn_o(dn), .fctl_o(fctl));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // 0 none, 1 advance (late), 2 retard (early)
   function automatic int classify(input logic a, input logic t, input logic b, input logic e, input logic v);
      if (!e || !v || a == b) return 0;
      if (t == a) return 2;
      return 1;
   endfunction

   function automatic int clamp(input int x);
      if (x > F_MAX) return F_MAX;
      if (x < F_MIN) return F_MIN;
      return x;
   endfunction

   // drive one cycle after a negedge, check at the following negedge
   task automatic cyc(input logic v, input logic a, input logic t, input logic b, input logic e);
      int d;
      vld = v; sa = a; st = t; sb = b; en = e;
      m_freq = clamp(m_freq + m_pend * INT_STEP);
      d = classify(a, t, b, e, v);
      m_pend = 0;
      if (!e) begin
         m_cnt = 0; m_dir = 0;
      end else if (d != 0) begin
         if (d == m_dir) m_cnt = (m_cnt < RUN_MIN) ? m_cnt + 1 : RUN_MIN;
         else m_cnt = 1;
         m_dir = d;
         if (m_cnt >= RUN_MIN) m_pend = (d == 1) ? 1 : -1;
      end
      if (v) m_dout = a;
      @(negedge clk);
      if (!v) check("R12 quiet", int'(rdata_vld_o_w()), 0);
      check("R2 data", int'(rdata), int'(m_dout));
      check("R2 data valid", int'(rvld), int'(v));
      if (v && a == b) check("R3 no transition", int'(up | dn), 0);
      if (!e) check("R7 disabled", int'(up | dn), 0);
      check("R5 advance", int'(up), int'(d == 1));
      check("R4 retard", int'(dn), int'(d == 2));
      check("R8 exclusive", int'(up & dn), 0);
      check("R9 R10 R11 freq", int'(fctl), m_freq);
   endtask

   function automatic logic rdata_vld_o_w();
      return rvld;
   endfunction

   initial begin : watchdog
      #1000000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = $urandom(32'd4711);
      repeat (3) @(negedge clk);
      check("R1 reset data", int'(rdata), 0);
      check("R1 reset up/dn", int'(up | dn | rvld), 0);
      check("R1 reset freq", int'(fctl), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset freq", int'(fctl), 0);

      // R3: centres agree, edge differs
      cyc(1, 0, 1, 0, 1);
      cyc(1, 1, 0, 1, 1);
      // R4 and R5 single pulses, then R6 one-cycle width
      cyc(1, 1, 1, 0, 1);
      cyc(0, 0, 0, 0, 1);
      cyc(1, 0, 1, 1, 1);
      cyc(0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 1);
      // R10: late, hold, late -> one step; then reversal restarts run
      cyc(1, 1, 0, 0, 1);
      cyc(1, 1, 1, 1, 1);
      cyc(1, 1, 0, 0, 1);
      cyc(1, 0, 0, 1, 1);
      cyc(1, 1, 1, 0, 1);
      cyc(1, 0, 1, 1, 1);
      cyc(0, 0, 0, 0, 1);
      // R7: disable mid run clears it
      cyc(1, 1, 0, 0, 1);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 1, 0, 0, 1);
      cyc(0, 0, 0, 0, 1);
      // R11: drive into positive rail and hold there
      for (int i = 0; i < 45; i++) cyc(1, 1, 0, 0, 1);
      cyc(0, 0, 0, 0, 1);
      check("R11 positive rail", int'(fctl), F_MAX);
      // R11: drive into negative rail
      for (int i = 0; i < 80; i++) cyc(1, 0, 0, 1, 1);
      cyc(0, 0, 0, 0, 1);
      check("R11 negative rail", int'(fctl), F_MIN);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [4:0] r;
         r = 5'($urandom);
         cyc(r[0] | r[4], r[1], r[2], r[3], ($urandom % 8) != 0);
      end
      cyc(0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule